// File: doc/BRIEF.md
# Sensorless Brushless Motor Startup Sequencer

This block chooses the operating mode of a three-phase sensorless brushless motor drive. After a valid speed command it holds the rotor in a fixed alignment position until an external timer reports that alignment is done. It then steps the six-step commutation state open-loop at a crystal-derived rate. When the motor's back-EMF comparators show that the rotor is already turning faster than that forced rate, it hands over to closed-loop commutation. In closed loop, each valid comparator transition advances the commutation state.

In closed loop the block watches the time between accepted position changes. A step that arrives too soon, or a gap longer than the forced step period, is a fault. A fault turns the drive off, waits a programmable restart delay and runs the whole startup again. A toggle output marks every electrical revolution. The analog timing networks and the comparators are modelled as a strobe and three digital bits.

Top module: `bldc_startup_seq`

## Requirements
- R1: In synchronous reset, `mode` is 0 (idle), `comm_step` is 0, and `drive_en` and `speed_pulse` are 0.
- R2: Modes are encoded 0 idle, 1 align, 2 forced, 3 closed loop, 4 fault. In idle, `cmd_valid` high moves the block to align on the next clock. `drive_en` is 1 only in align, forced and closed loop. `align_done` has no effect outside align. In align, `comm_step` stays 0 whatever `phase_cmp` shows. `align_done` moves the block from align to forced.
- R3: In forced mode the commutation state advances one step every P cycles, with P = 2^(FORCE_SHIFT+s). Here s equals `force_sel` for values 0 to 2, and `force_sel`=3 acts as 2. The first step comes P cycles after forced mode is entered.
- R4: A position change counts as fast when it is accepted less than P cycles after the previous accepted change, or after entry to forced mode. LOCK_STEPS consecutive fast changes move the block to closed loop, with `comm_step` set to the step just accepted. A change that is not fast restarts the count.
- R5: Position codes on `phase_cmp` for steps 0 to 5 are 001, 011, 010, 110, 100, 101. In closed loop, `comm_step` moves to the next step in the current direction two clocks after `phase_cmp` first shows that step's code.
- R6: The codes 000 and 111 are ignored, and so are valid codes that are not the next step in the current direction.
- R7: With `reverse`=0 the step number counts up (5 wraps to 0). With `reverse`=1 it counts down (0 wraps to 5).
- R8: `speed_pulse` toggles exactly once in every six commutation advances and is 0 whenever the mode is not forced or closed loop.
- R9: In closed loop, an accepted change whose spacing from the previous one is below MIN_GAP_0 cycles (`limit_sel`=0) or MIN_GAP_1 cycles (`limit_sel`=1) moves the block to fault with `drive_en` 0. A spacing equal to the limit is allowed.
- R10: The block leaves fault for align exactly RESTART_CYCLES cycles after it entered fault.
- R11: In closed loop, a gap of more than P cycles after the last accepted change moves the block to fault.
- R12: `cmd_valid` low moves the block to idle on the next clock from any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (the crystal-derived timebase) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Speed command present |
| align_done | input | 1 | Strobe: alignment time has elapsed |
| force_sel | input | 2 | Forced step rate select |
| reverse | input | 1 | Rotation direction, 1 = reverse |
| limit_sel | input | 1 | Maximum commutation rate select |
| phase_cmp | input | 3 | Back-EMF comparator polarity bits |
| mode | output | 3 | Current mode |
| comm_step | output | 3 | Six-step commutation state, 0 to 5 |
| speed_pulse | output | 1 | Toggles once per electrical revolution |
| drive_en | output | 1 | Output stage enable |

## Verification
The hardest conditions to reach are the exact limits of the closed-loop rate checks. They lie beyond an alignment phase, a timed forced phase and a handover that needs several fast steps in a row. The bench shrinks the timing parameters and uses one task to walk through startup. It then drives comparator codes at cycle-counted spacings: exactly at the minimum spacing and one cycle below it, and exactly at the forced period and one cycle past it. It then checks the mode on the predicted cycle, and checks the restart timing after each fault.

// File: rtl/bldc_seq_pkg.sv
package bldc_seq_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE    = 3'd0,
    MODE_ALIGN   = 3'd1,
    MODE_FORCED  = 3'd2,
    MODE_NATURAL = 3'd3,
    MODE_FAULT   = 3'd4
  } mode_t;

  // Comparator pattern expected while the rotor sits in a given step
  function automatic logic [2:0] step_code(input logic [2:0] s);
    case (s)
      3'd0:    step_code = 3'b001;
      3'd1:    step_code = 3'b011;
      3'd2:    step_code = 3'b010;
      3'd3:    step_code = 3'b110;
      3'd4:    step_code = 3'b100;
      3'd5:    step_code = 3'b101;
      default: step_code = 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] step_next(input logic [2:0] s, input logic rev);
    if (rev) step_next = (s == 3'd0) ? 3'd5 : s - 3'd1;
    else     step_next = (s == 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

endpackage

// File: rtl/bldc_force_timer.sv
module bldc_force_timer #(
  parameter int FORCE_SHIFT = 16,
  parameter int CNT_W       = FORCE_SHIFT + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       sel,
  output logic             tick,
  output logic [CNT_W-1:0] period
);

  logic [1:0]       sh;
  logic [CNT_W-1:0] cnt_q;

  assign sh     = (sel == 2'd3) ? 2'd2 : sel;
  assign period = CNT_W'(1) << (FORCE_SHIFT + int'(sh));
  assign tick   = run && (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  // Forced steps are never back to back
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/bldc_pos_tracker.sv
module bldc_pos_tracker
  import bldc_seq_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             rev,
  input  logic [2:0]       phase,
  output logic             acc,
  output logic [2:0]       acc_step,
  output logic [CNT_W-1:0] ivl
);

  logic [2:0]       pos_q;
  logic [2:0]       ref_q;
  logic [CNT_W-1:0] ivl_q;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= phase;
  end

  assign acc_step = step_next(ref_q, rev);
  assign acc      = en && (pos_q == step_code(acc_step));
  assign ivl      = ivl_q;

  // ivl_q counts clock edges since the last accepted change
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ref_q <= '0;
      ivl_q <= CNT_W'(1);
    end else if (acc) begin
      ref_q <= acc_step;
      ivl_q <= CNT_W'(1);
    end else if (ivl_q != '1) begin
      ivl_q <= ivl_q + CNT_W'(1);
    end
  end

  assert_accept_valid_code_R6: assert property (@(posedge clk) disable iff (rst)
    acc |-> (pos_q != 3'b000 && pos_q != 3'b111));

endmodule

// File: rtl/bldc_speed_tog.sv
module bldc_speed_tog #(
  parameter int STEPS = 6,
  localparam int SW   = $clog2(STEPS)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic spd
);

  logic [SW-1:0] cnt_q;
  logic          spd_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      spd_q <= 1'b0;
    end else if (adv) begin
      if (cnt_q == SW'(STEPS - 1)) begin
        cnt_q <= '0;
        spd_q <= ~spd_q;
      end else begin
        cnt_q <= cnt_q + SW'(1);
      end
    end
  end

  assign spd = spd_q;

  assert_toggle_only_on_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(adv) && !$past(clr)) |-> $stable(spd_q));

endmodule

// File: rtl/bldc_startup_seq.sv
module bldc_startup_seq
  import bldc_seq_pkg::*;
#(
  parameter int FORCE_SHIFT    = 16,
  parameter int MIN_GAP_0      = 256,
  parameter int MIN_GAP_1      = 512,
  parameter int RESTART_CYCLES = 4000000,
  parameter int LOCK_STEPS     = 6,
  localparam int CNT_W = FORCE_SHIFT + 3,
  localparam int RS_W  = $clog2(RESTART_CYCLES + 1),
  localparam int LK_W  = $clog2(LOCK_STEPS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic       align_done,
  input  logic [1:0] force_sel,
  input  logic       reverse,
  input  logic       limit_sel,
  input  logic [2:0] phase_cmp,
  output logic [2:0] mode,
  output logic [2:0] comm_step,
  output logic       speed_pulse,
  output logic       drive_en
);

  mode_t            mode_q, mode_d;
  logic [2:0]       comm_q, comm_d;
  logic [LK_W-1:0]  lock_q, lock_d;
  logic [RS_W-1:0]  rs_q;
  logic             en_q;
  logic             trk_on, adv, spd_clr;
  logic             tick, acc;
  logic [2:0]       acc_step;
  logic [CNT_W-1:0] period, ivl, min_lim;
  logic             fast, too_fast, too_slow;

  assign trk_on = (mode_q == MODE_FORCED) || (mode_q == MODE_NATURAL);

  bldc_force_timer #(.FORCE_SHIFT(FORCE_SHIFT), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run(mode_q == MODE_FORCED), .sel(force_sel),
    .tick(tick), .period(period)
  );

  bldc_pos_tracker #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst(rst), .clr(!trk_on), .en(trk_on), .rev(reverse),
    .phase(phase_cmp), .acc(acc), .acc_step(acc_step), .ivl(ivl)
  );

  assign min_lim  = limit_sel ? CNT_W'(MIN_GAP_1) : CNT_W'(MIN_GAP_0);
  assign fast     = ivl < period;
  assign too_fast = acc && (ivl < min_lim);
  assign too_slow = ivl > period;

  always_comb begin
    mode_d = mode_q;
    comm_d = comm_q;
    lock_d = lock_q;
    adv    = 1'b0;
    case (mode_q)
      MODE_IDLE:  if (cmd_valid) mode_d = MODE_ALIGN;
      MODE_ALIGN: if (align_done) mode_d = MODE_FORCED;
      MODE_FORCED: begin
        if (acc) begin
          if (!fast) begin
            lock_d = '0;
          end else if (lock_q == LK_W'(LOCK_STEPS - 1)) begin
            mode_d = MODE_NATURAL;
            comm_d = acc_step;
          end else begin
            lock_d = lock_q + LK_W'(1);
          end
        end
        if (tick && mode_d == MODE_FORCED) begin
          comm_d = step_next(comm_q, reverse);
          adv    = 1'b1;
        end
      end
      MODE_NATURAL: begin
        if (too_fast || too_slow) begin
          mode_d = MODE_FAULT;
        end else if (acc) begin
          comm_d = acc_step;
          adv    = 1'b1;
        end
      end
      MODE_FAULT: if (rs_q == RS_W'(RESTART_CYCLES - 1)) mode_d = MODE_ALIGN;
      default:    mode_d = MODE_IDLE;
    endcase
    if (!cmd_valid) mode_d = MODE_IDLE;
    if (mode_d != MODE_FORCED) lock_d = '0;
    if (mode_d != MODE_FORCED && mode_d != MODE_NATURAL) comm_d = 3'd0;
  end

  assign spd_clr = (mode_d != MODE_FORCED) && (mode_d != MODE_NATURAL);

  bldc_speed_tog #(.STEPS(6)) u_speed (
    .clk(clk), .rst(rst), .clr(spd_clr), .adv(adv), .spd(speed_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      comm_q <= 3'd0;
      lock_q <= '0;
      rs_q   <= '0;
      en_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      comm_q <= comm_d;
      lock_q <= lock_d;
      rs_q   <= (mode_q == MODE_FAULT) ? rs_q + RS_W'(1) : '0;
      en_q   <= (mode_d == MODE_ALIGN) || (mode_d == MODE_FORCED) ||
                (mode_d == MODE_NATURAL);
    end
  end

  assign mode      = mode_q;
  assign comm_step = comm_q;
  assign drive_en  = en_q;

  assert_cmd_drop_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (mode_q == MODE_IDLE));

  assert_dark_when_stopped_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IDLE || mode_q == MODE_FAULT) |-> !drive_en);

  assert_forced_after_align_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FORCED) |->
      ($past(mode_q) == MODE_FORCED || $past(mode_q) == MODE_ALIGN));

  assert_natural_after_forced_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NATURAL) |->
      ($past(mode_q) == MODE_NATURAL || $past(mode_q) == MODE_FORCED));

  assert_fault_exit_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FAULT) |=>
      (mode_q == MODE_FAULT || mode_q == MODE_ALIGN || mode_q == MODE_IDLE));

endmodule

// File: tb/test_bldc_startup_seq.sv
module test_bldc_startup_seq;

  localparam int FS      = 4;
  localparam int RESTART = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, align_done = 1'b0, reverse = 1'b0, limit_sel = 1'b0;
  logic [1:0] force_sel = 2'd0;
  logic [2:0] phase_cmp = 3'b000;
  logic [2:0] mode, comm_step;
  logic       speed_pulse, drive_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bldc_startup_seq #(
    .FORCE_SHIFT(FS), .MIN_GAP_0(4), .MIN_GAP_1(6),
    .RESTART_CYCLES(RESTART), .LOCK_STEPS(3)
  ) i_bldc_startup_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .align_done(align_done),
    .force_sel(force_sel), .reverse(reverse), .limit_sel(limit_sel),
    .phase_cmp(phase_cmp), .mode(mode), .comm_step(comm_step),
    .speed_pulse(speed_pulse), .drive_en(drive_en)
  );

  // {reverse, code, hold cycles, expected step}, walked in closed loop from step 4
  localparam logic [10:0] NAT_VEC [15] = '{
    {1'b0, 3'b101, 4'd6, 3'd5}, {1'b0, 3'b000, 4'd3, 3'd5},
    {1'b0, 3'b011, 4'd3, 3'd5}, {1'b0, 3'b001, 4'd6, 3'd0},
    {1'b0, 3'b011, 4'd6, 3'd1}, {1'b0, 3'b010, 4'd6, 3'd2},
    {1'b0, 3'b010, 4'd4, 3'd2}, {1'b1, 3'b011, 4'd6, 3'd1},
    {1'b1, 3'b001, 4'd6, 3'd0}, {1'b1, 3'b100, 4'd4, 3'd0},
    {1'b1, 3'b101, 4'd6, 3'd5}, {1'b0, 3'b100, 4'd4, 3'd5},
    {1'b0, 3'b001, 4'd6, 3'd0}, {1'b0, 3'b111, 4'd3, 3'd0},
    {1'b0, 3'b011, 4'd6, 3'd1}
  };

  function automatic logic [2:0] cod(input int s);
    case (s % 6)
      0: cod = 3'b001;
      1: cod = 3'b011;
      2: cod = 3'b010;
      3: cod = 3'b110;
      4: cod = 3'b100;
      default: cod = 3'b101;
    endcase
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // From align: check forced step timing, then lock with four position changes
  task automatic bring_up(input logic [1:0] sel, input int p);
    reverse   = 1'b0;
    force_sel = sel;
    phase_cmp = cod(0);
    align_done = 1'b1;
    wait_n(1);
    align_done = 1'b0;
    check("R2", "mode after align_done", mode, 2);
    wait_n(p - 1);
    check("R3", "step before first forced step", comm_step, 0);
    wait_n(1);
    check("R3", "step at first forced step", comm_step, 1);
    for (int k = 1; k <= 4; k++) begin
      phase_cmp = cod(k);
      wait_n(2);
      if (k == 3) check("R4", "still forced after two fast changes", mode, 2);
      if (k == 4) begin
        check("R4", "mode after handover", mode, 3);
        check("R4", "step after handover", comm_step, 4);
      end
      wait_n(4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0] prev_exp;
    logic       prev_spd;
    int         changes;

    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    check("R1", "mode in reset", mode, 0);
    check("R1", "step in reset", comm_step, 0);
    check("R1", "enable in reset", drive_en, 0);
    check("R1", "speed in reset", speed_pulse, 0);

    align_done = 1'b1;
    wait_n(1);
    align_done = 1'b0;
    check("R2", "align_done ignored in idle", mode, 0);
    cmd_valid = 1'b1;
    wait_n(1);
    check("R2", "mode after command", mode, 1);
    check("R2", "enable in align", drive_en, 1);
    phase_cmp = cod(1);
    wait_n(5);
    check("R2", "position ignored in align", comm_step, 0);
    check("R2", "still aligning", mode, 1);

    bring_up(2'd0, 16);

    prev_exp = 3'd4;
    for (int i = 0; i < 15; i++) begin
      logic [10:0] v;
      string tag;
      v = NAT_VEC[i];
      reverse   = v[10];
      phase_cmp = v[9:7];
      wait_n(2);
      tag = (v[2:0] == prev_exp) ? "R6" : (v[10] ? "R7" : "R5");
      check(tag, "closed-loop step", comm_step, 32'(v[2:0]));
      check(tag, "closed-loop mode", mode, 3);
      prev_exp = v[2:0];
      wait_n(int'(v[6:3]) - 2);
    end

    reverse = 1'b0;
    for (int r = 0; r < 2; r++) begin
      changes  = 0;
      prev_spd = speed_pulse;
      for (int k = 0; k < 6; k++) begin
        phase_cmp = cod(2 + 6 * r + k);
        wait_n(2);
        if (speed_pulse != prev_spd) changes++;
        prev_spd = speed_pulse;
        wait_n(4);
      end
      check("R8", "speed toggles per six steps", changes, 1);
    end

    limit_sel = 1'b0;
    phase_cmp = cod(2);
    wait_n(2);
    check("R5", "step before rate test", comm_step, 2);
    wait_n(2);
    phase_cmp = cod(3);
    wait_n(2);
    check("R9", "spacing equal to limit allowed", mode, 3);
    check("R9", "step at limit spacing", comm_step, 3);
    wait_n(1);
    phase_cmp = cod(4);
    wait_n(2);
    check("R9", "fault on short spacing", mode, 4);
    check("R9", "enable off in fault", drive_en, 0);
    check("R8", "speed low in fault", speed_pulse, 0);
    wait_n(RESTART - 1);
    check("R10", "still in fault before restart", mode, 4);
    wait_n(1);
    check("R10", "align after restart delay", mode, 1);
    check("R10", "enable after restart", drive_en, 1);

    bring_up(2'd1, 32);
    limit_sel = 1'b1;
    phase_cmp = cod(5);
    wait_n(2);
    check("R9", "spacing at upper limit allowed", mode, 3);
    wait_n(3);
    phase_cmp = cod(0);
    wait_n(2);
    check("R9", "fault below upper limit", mode, 4);
    wait_n(RESTART);
    check("R10", "align after second restart", mode, 1);

    limit_sel = 1'b0;
    bring_up(2'd3, 64);
    phase_cmp = cod(5);
    wait_n(2);
    check("R11", "step before stall", comm_step, 5);
    wait_n(64);
    check("R11", "no fault at gap of one period", mode, 3);
    wait_n(1);
    check("R11", "fault past one period", mode, 4);

    cmd_valid = 1'b0;
    wait_n(1);
    check("R12", "idle after command drop", mode, 0);
    check("R12", "enable off after drop", drive_en, 0);
    check("R12", "step zero after drop", comm_step, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule